// File: doc/BRIEF.md
# SCL timing generator

This block produces the serial clock for an I2C byte engine, together with the bit-phase strobes that tell the engine when to move SDA, when to sample it, when a START has been held long enough and when a STOP may be finished. The low time and the high time of SCL are set by two independent 32-bit counts. Each count is split by half-word across two divider registers. A third register gives the start-hold time, which is how many clocks SCL stays high after the engine pulls SDA low for a START. Software computes all three values. A typical choice is a high time of about 40% and a low time of about 60% of the SCL period, but the block uses whatever counts it is given.

The master engine controls the generator with two levels, `run` and `stop`. While `run` is high, each low phase is followed by a high phase. When `stop` is high at the end of a low phase, the generator releases SCL, waits a full high count and then strobes `stop_done`. After that strobe the engine releases SDA. The high phase starts counting only once the bus line is seen high, so a target that holds SCL low is waited for. When neither level is high at the end of a low phase, SCL is held low until the engine decides.

Top module: `scl_timing_gen`

## Requirements
- R1: While idle, `scl_out` is 1 (released) and no strobe is asserted. `stop` is ignored in the idle state.
- R2: A write with `cfg_sel`=0 loads the lower half-words and `cfg_sel`=1 loads the upper half-words. In each case `cfg_wdata[31:16]` goes to the high count and `cfg_wdata[15:0]` goes to the low count. `cfg_sel`=2 loads the 32-bit start-hold count.
- R3: A low phase drives `scl_out` to 0 for exactly max(low count, 1) clock cycles.
- R4: After a low phase, SCL is released for one cycle while the line is observed. When `scl_in` is high, a high phase of max(high count, 1) cycles follows. An unstretched released time is therefore high count + 1 cycles.
- R5: While `scl_in` stays low after SCL is released, the high phase does not start and no sample strobe is given.
- R6: When `run` rises from idle, SCL stays high for max(hold count, 1) cycles. `hold_done` is asserted in the last of those cycles, and SCL falls on the next cycle.
- R7: `sda_chg` is asserted once per low phase, in the cycle at index (L-1)/2 (rounded down) of a phase that lasts L cycles. `sda_smp` is asserted once per high phase, in the cycle at index (H-1)/2 of a phase that lasts H cycles. No two strobes are ever asserted together.
- R8: If `stop` is high at the end of a low phase, SCL is released for one observation cycle, followed by max(high count, 1) cycles. `stop_done` is asserted in the last of those cycles, and the block then returns to idle. `stop` takes priority over `run`.
- R9: If neither `run` nor `stop` is high at the end of a low phase, SCL is held low with no strobes. One cycle after `run` or `stop` is raised, the release begins.
- R10: A count of zero in any of the three timings behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 lower halves, 1 upper halves, 2 start hold |
| cfg_wdata | input | CNT_W | Register write data |
| run | input | 1 | Engine requests a START and continued clocking |
| stop | input | 1 | Engine requests a STOP at the end of the current low phase |
| scl_in | input | 1 | Observed SCL line level (already synchronised) |
| scl_out | output | 1 | 1 releases SCL, 0 pulls it low |
| sda_chg | output | 1 | Strobe: SDA may change now |
| sda_smp | output | 1 | Strobe: sample SDA now |
| hold_done | output | 1 | Strobe: start hold has elapsed |
| stop_done | output | 1 | Strobe: STOP setup has elapsed; SDA may be released |

## Verification
The bound checker covers the following on every cycle:
- the idle state is quiet;
- the strobes never overlap;
- `sda_chg` appears only while SCL is pulled low;
- a held-low line keeps the generator waiting in the release state;
- SCL falls right after `hold_done`;
- `stop_done` always leads back to idle;
- a paused low phase stays silent.

The exact phase lengths, the index of every strobe inside its phase, the half-word packing of both counts (including counts beyond 16 bits), the zero-count rule and the resume from a pause depend on the programmed values. These are shown only by the bench's directed scenarios, which compare every cycle of each phase against values computed from the counts.

// File: rtl/scl_tg_pkg.sv
// Shared types for the SCL timing generator.
// Assumes: a single clock domain; the select codes match the divider bank index.
package scl_tg_pkg;

    // Generator phases.
    typedef enum logic [2:0] {
        TG_IDLE      = 3'd0,
        TG_HOLD      = 3'd1,
        TG_LOW       = 3'd2,
        TG_PAUSE     = 3'd3,
        TG_RISE      = 3'd4,
        TG_HIGH      = 3'd5,
        TG_STOP_RISE = 3'd6,
        TG_STOP_HIGH = 3'd7
    } tg_state_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_DIV_LO = 2'd0;
    localparam logic [SEL_W-1:0] SEL_DIV_HI = 2'd1;
    localparam logic [SEL_W-1:0] SEL_HOLD   = 2'd2;

endpackage

// File: rtl/scl_tg_regs.sv
// Timing registers. Each of the two divider banks holds one half-word of the
// high count (upper half of the write data) and one half-word of the low
// count (lower half). Bank 0 holds the lower halves, bank 1 the upper halves.
// Assumes: CNT_W is even; the select code of a bank equals its index.
module scl_tg_regs
    import scl_tg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] high_cnt,
    output logic [CNT_W-1:0] low_cnt,
    output logic [CNT_W-1:0] hold_cnt
);
    localparam int HALF_W  = CNT_W / 2;
    localparam int NUM_DIV = 2;

    generate
        for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
            logic [HALF_W-1:0] hi_q;
            logic [HALF_W-1:0] lo_q;

            // Capture one half-word of each count when this bank is selected.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hi_q <= '0;
                    lo_q <= '0;
                end else if (cfg_we && cfg_sel == SEL_W'(g)) begin
                    hi_q <= cfg_wdata[CNT_W-1:HALF_W];
                    lo_q <= cfg_wdata[HALF_W-1:0];
                end
            end
        end
    endgenerate

    // Capture the start-hold count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (cfg_we && cfg_sel == SEL_HOLD) begin
            hold_cnt <= cfg_wdata;
        end
    end

    assign high_cnt = {g_div[1].hi_q, g_div[0].hi_q};
    assign low_cnt  = {g_div[1].lo_q, g_div[0].lo_q};

endmodule

// File: rtl/scl_tg_phase_cnt.sv
// Phase counter. Counts 0 .. max(limit,1)-1 and flags the last cycle and the
// midpoint cycle (index (last)/2, rounded down).
// Assumes: the limit stays steady during a phase; clr has priority over en.
module scl_tg_phase_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             at_mid,
    output logic             at_end
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Zero is treated as a one-cycle phase.
    assign last   = (limit == '0) ? '0 : limit - CNT_W'(1);
    assign at_end = (cnt_q == last);
    assign at_mid = (cnt_q == (last >> 1));

    // Advance through the phase, holding at the last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && !at_end) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/scl_tg_fsm.sv
// Phase sequencer. Steps through start hold, low, release, high and stop
// phases under the engine's run/stop levels and the observed SCL line.
// Assumes: scl_in is synchronous to clk; stop has priority over run.
module scl_tg_fsm
    import scl_tg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      stop,
    input  logic      scl_in,
    input  logic      at_end,
    output tg_state_e state,
    output logic      cnt_en,
    output logic      cnt_clr
);
    tg_state_e state_d;
    logic      counting;

    // Phases that run the counter.
    assign counting = (state == TG_HOLD) || (state == TG_LOW) ||
                      (state == TG_HIGH) || (state == TG_STOP_HIGH);
    assign cnt_en   = counting;
    assign cnt_clr  = !counting || at_end;

    // Choose the next phase.
    always_comb begin
        state_d = state;
        unique case (state)
            TG_IDLE:      if (run) state_d = TG_HOLD;
            TG_HOLD:      if (at_end) state_d = TG_LOW;
            TG_LOW: begin
                if (at_end) begin
                    if (stop)     state_d = TG_STOP_RISE;
                    else if (run) state_d = TG_RISE;
                    else          state_d = TG_PAUSE;
                end
            end
            TG_PAUSE: begin
                if (stop)     state_d = TG_STOP_RISE;
                else if (run) state_d = TG_RISE;
            end
            TG_RISE:      if (scl_in) state_d = TG_HIGH;
            TG_HIGH:      if (at_end) state_d = TG_LOW;
            TG_STOP_RISE: if (scl_in) state_d = TG_STOP_HIGH;
            TG_STOP_HIGH: if (at_end) state_d = TG_IDLE;
            default:      state_d = TG_IDLE;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TG_IDLE;
        else        state <= state_d;
    end

endmodule

// File: rtl/scl_timing_gen.sv
// SCL timing generator top. Selects the count for the current phase, drives
// SCL and decodes the four bit-phase strobes from phase and counter.
// Assumes: the engine drives SDA itself, using the strobes as its timing.
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             run,
    input  logic             stop,
    input  logic             scl_in,
    output logic             scl_out,
    output logic             sda_chg,
    output logic             sda_smp,
    output logic             hold_done,
    output logic             stop_done
);
    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] hold_cnt;
    logic [CNT_W-1:0] phase_lim;
    logic             at_mid;
    logic             at_end;
    logic             cnt_en;
    logic             cnt_clr;
    tg_state_e        state;

    scl_tg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .high_cnt  (high_cnt),
        .low_cnt   (low_cnt),
        .hold_cnt  (hold_cnt)
    );

    scl_tg_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .stop    (stop),
        .scl_in  (scl_in),
        .at_end  (at_end),
        .state   (state),
        .cnt_en  (cnt_en),
        .cnt_clr (cnt_clr)
    );

    // Pick the count that governs the current phase.
    always_comb begin
        unique case (state)
            TG_HOLD:                phase_lim = hold_cnt;
            TG_LOW:                 phase_lim = low_cnt;
            TG_HIGH, TG_STOP_HIGH:  phase_lim = high_cnt;
            default:                phase_lim = '0;
        endcase
    end

    scl_tg_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .en     (cnt_en),
        .limit  (phase_lim),
        .at_mid (at_mid),
        .at_end (at_end)
    );

    assign scl_out   = !((state == TG_LOW) || (state == TG_PAUSE));
    assign sda_chg   = (state == TG_LOW)       && at_mid;
    assign sda_smp   = (state == TG_HIGH)      && at_mid;
    assign hold_done = (state == TG_HOLD)      && at_end;
    assign stop_done = (state == TG_STOP_HIGH) && at_end;

endmodule

// File: rtl/scl_tg_chk.sv
// Cycle checker for the SCL timing generator, bound to the top module.
// Assumes: synchronous active-low reset; scl_in is the observed bus line.
module scl_tg_chk
    import scl_tg_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input tg_state_e state,
    input logic      scl_in,
    input logic      scl_out,
    input logic      sda_chg,
    input logic      sda_smp,
    input logic      hold_done,
    input logic      stop_done
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TG_IDLE) |-> (scl_out && !sda_chg && !sda_smp && !hold_done && !stop_done)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sda_chg, sda_smp, hold_done, stop_done})); // R7

    AST_CHG_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg |-> !scl_out); // R7

    AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_out) |-> (state == TG_RISE || state == TG_STOP_RISE)); // R4

    AST_WAIT_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TG_RISE && !scl_in) |=> (state == TG_RISE && !sda_smp)); // R5

    AST_HOLD_LINE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |-> scl_out); // R6

    AST_HOLD_THEN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |=> !scl_out); // R6

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> (state == TG_IDLE && scl_out)); // R8

    AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TG_PAUSE) |-> (!scl_out && !sda_chg && !sda_smp)); // R9

endmodule

bind scl_timing_gen scl_tg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .scl_in    (scl_in),
    .scl_out   (scl_out),
    .sda_chg   (sda_chg),
    .sda_smp   (sda_smp),
    .hold_done (hold_done),
    .stop_done (stop_done)
);

// File: tb/sim_scl_timing_gen.sv
// Directed bench for the SCL timing generator. Every phase is checked cycle
// by cycle against lengths and strobe indices computed from the counts.
module sim_scl_timing_gen;

    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          run = 1'b0;
    logic          stop = 1'b0;
    logic          stretch = 1'b0;
    logic          scl_in;
    logic          scl_out, sda_chg, sda_smp, hold_done, stop_done;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    assign scl_in = scl_out & ~stretch;

    always #10 clk = ~clk;

    scl_timing_gen #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .run(run), .stop(stop), .scl_in(scl_in),
        .scl_out(scl_out), .sda_chg(sda_chg), .sda_smp(sda_smp),
        .hold_done(hold_done), .stop_done(stop_done)
    );

    function automatic int eff(logic [31:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [1:0] s, logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic cfg_counts(logic [31:0] h, logic [31:0] l, logic [31:0] hd);
        cfg_write(2'd0, {h[15:0], l[15:0]});
        cfg_write(2'd1, {h[31:16], l[31:16]});
        cfg_write(2'd2, hd);
    endtask

    // Check n cycles: scl level and the strobe vector {stop,hold,smp,chg};
    // strobe number "which" is expected only at index idx.
    task automatic expect_phase(string tag, string what, int n, bit scl, int idx, int which);
        int bad = 0;
        int bi = 0;
        logic bscl = 1'b0;
        logic [3:0] bseen = '0, bexp = '0;
        for (int i = 0; i < n; i++) begin
            logic [3:0] seen, exp;
            seen = {stop_done, hold_done, sda_smp, sda_chg};
            exp  = (i == idx) ? 4'(1 << which) : 4'b0;
            if (scl_out !== scl || seen !== exp) begin
                if (bad == 0) begin bi = i; bscl = scl_out; bseen = seen; bexp = exp; end
                bad++;
            end
            step();
        end
        n_chk++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s %s: cycle %0d of %0d actual scl=%b strobes=%b expected scl=%b strobes=%b",
                     tag, what, bi, n, bscl, bseen, scl, bexp);
        end
    endtask

    task automatic ph_hold(logic [31:0] hd, string tag);
        expect_phase(tag, "start hold", eff(hd), 1'b1, eff(hd) - 1, 2);
    endtask
    task automatic ph_low(logic [31:0] l, string tag);
        expect_phase(tag, "low phase", eff(l), 1'b0, (eff(l) - 1) / 2, 0);
    endtask
    task automatic ph_rise(string tag);
        expect_phase(tag, "release", 1, 1'b1, -1, 0);
    endtask
    task automatic ph_high(logic [31:0] h, string tag);
        expect_phase(tag, "high phase", eff(h), 1'b1, (eff(h) - 1) / 2, 1);
    endtask
    task automatic ph_stop(logic [31:0] h, string tag);
        expect_phase(tag, "stop release", 1, 1'b1, -1, 0);
        expect_phase(tag, "stop setup", eff(h), 1'b1, eff(h) - 1, 3);
    endtask
    task automatic ph_idle(int n, string tag);
        expect_phase(tag, "idle", n, 1'b1, -1, 0);
    endtask

    // R1: reset state and idle quiet, with stop ignored while idle.
    task automatic t_reset();
        stop = 1'b1;
        ph_idle(6, "R1");
        stop = 1'b0;
        ph_idle(2, "R1");
    endtask

    // Full frame of several bits ended by a STOP (R3, R4, R6, R7, R8).
    task automatic t_frame(logic [31:0] h, logic [31:0] l, logic [31:0] hd, int bits, string tag);
        cfg_counts(h, l, hd);
        run = 1'b1;
        step();
        ph_hold(hd, {tag, " R6"});
        for (int b = 0; b < bits; b++) begin
            if (b == bits - 1) begin run = 1'b0; stop = 1'b1; end
            ph_low(l, {tag, " R3,R7"});
            if (b < bits - 1) begin
                ph_rise({tag, " R4"});
                ph_high(h, {tag, " R4,R7"});
            end
        end
        ph_stop(h, {tag, " R8"});
        stop = 1'b0;
        ph_idle(3, {tag, " R8"});
    endtask

    // R2: upper half-word of the low count.
    task automatic t_pack_low();
        cfg_write(2'd0, 32'h0003_0002);
        cfg_write(2'd1, 32'h0000_0001);
        cfg_write(2'd2, 32'd2);
        run = 1'b1;
        step();
        ph_hold(32'd2, "R2");
        run = 1'b0; stop = 1'b1;
        ph_low(32'h0001_0002, "R2 low upper half");
        ph_stop(32'd3, "R2 high lower half");
        stop = 1'b0;
        ph_idle(2, "R2");
    endtask

    // R2: upper half-word of the high count.
    task automatic t_pack_high();
        cfg_write(2'd0, 32'h0003_0002);
        cfg_write(2'd1, 32'h0001_0000);
        run = 1'b1;
        step();
        ph_hold(32'd2, "R2");
        run = 1'b0; stop = 1'b1;
        ph_low(32'd2, "R2 low lower half");
        ph_stop(32'h0001_0003, "R2 high upper half");
        stop = 1'b0;
        ph_idle(2, "R2");
    endtask

    // R5: target holds SCL low after release.
    task automatic t_stretch();
        cfg_counts(32'd5, 32'd4, 32'd2);
        run = 1'b1;
        step();
        ph_hold(32'd2, "R5");
        ph_low(32'd4, "R5");
        stretch = 1'b1;
        expect_phase("R5", "stretched release", 7, 1'b1, -1, 0);
        stretch = 1'b0;
        ph_rise("R5");
        ph_high(32'd5, "R5");
        run = 1'b0; stop = 1'b1;
        ph_low(32'd4, "R5");
        ph_stop(32'd5, "R5");
        stop = 1'b0;
        ph_idle(2, "R5");
    endtask

    // R9: engine leaves both levels low at the end of a low phase.
    task automatic t_pause();
        cfg_counts(32'd3, 32'd5, 32'd2);
        run = 1'b1;
        step();
        ph_hold(32'd2, "R9");
        run = 1'b0;
        ph_low(32'd5, "R9");
        expect_phase("R9", "paused low", 6, 1'b0, -1, 0);
        run = 1'b1;
        expect_phase("R9", "pause exit", 1, 1'b0, -1, 0);
        ph_rise("R9");
        ph_high(32'd3, "R9");
        run = 1'b0; stop = 1'b1;
        ph_low(32'd5, "R9");
        ph_stop(32'd3, "R9");
        stop = 1'b0;
        ph_idle(2, "R9");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=still running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_frame(32'd4, 32'd6, 32'd3, 3, "R3 main");
        t_frame(32'd9, 32'd14, 32'd5, 4, "R4 wide");
        t_frame(32'd0, 32'd0, 32'd0, 3, "R10 zero");
        t_frame(32'd2, 32'd1, 32'd7, 2, "R7 short");
        t_stretch();
        t_pause();
        t_pack_low();
        t_pack_high();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule